// File: doc/BRIEF.md
# Flag Offset Register Load Sequencer

This block keeps the two threshold offsets that a FIFO's flag logic uses for its almost-empty and almost-full flags. Each offset is wider than the byte-wide data bus, so it is stored as a low byte and a high part. That makes four byte slots in total. While the reset input is asserted, the block samples the shared write-enable/load pin. If that pin is low during reset, the block enters load mode. If it is high, the pin acts as a plain second write enable and the offsets keep their defaults.

In load mode, software loads the slots one byte per clock through a write pointer that cycles through the slots in a fixed order. The pointer keeps its position between load sessions, so a session that writes only some of the slots is continued by the next one. The slots can be read back on the byte output. Readback uses a second cycling pointer of its own. A write and a read requested in the same cycle are reported on an error output, and the write wins. The assembled offsets drive the flag logic continuously.

Top module: `ofs_load_seq`

## Requirements
- R1: On every clock edge with `rstN` low, `loadMode` is set to the inverse of `wen2Ld`. After `rstN` goes high, `loadMode` holds that value until the next reset.
- R2: A reset sets both `emptyOffset` and `fullOffset` to 7, sets `dataOut` to 0, clears `collision`, and returns both the write pointer and the read pointer to slot 0.
- R3: A load write happens on a rising edge when `loadMode` is 1, `wen2Ld` is 0 and `wen1N` is 0. It stores `dataIn` in the slot the write pointer selects. Slot 0 is `emptyOffset[7:0]`, slot 1 is `emptyOffset[OFS_W-1:8]`, slot 2 is `fullOffset[7:0]` and slot 3 is `fullOffset[OFS_W-1:8]`.
- R4: After each load write the write pointer advances by one. A fifth write following four consecutive writes lands in slot 0 again.
- R5: Raising `wen2Ld` ends a load session without moving the write pointer. The next session continues at the slot after the last one written.
- R6: A readback happens on a rising edge when `loadMode` is 1 and `wen2Ld`, `ren1N` and `ren2N` are all 0. `dataOut` then shows the slot the read pointer selects, and the read pointer advances cyclically through slots 0 to 3, independently of the write pointer.
- R7: A write to slot 1 or slot 3 keeps only `dataIn[OFS_W-9:0]`; the higher bits are dropped. Reading back slot 1 or slot 3 returns zero in those higher bits.
- R8: If a load write and a readback are requested in the same cycle, the write is performed and `collision` is 1 for the following cycle. `dataOut` and the read pointer stay unchanged. At all other times `collision` is 0.
- R9: When `loadMode` is 0, no combination of `wen1N`, `wen2Ld`, `ren1N` and `ren2N` changes the offsets, `dataOut` or either pointer.
- R10: `dataOut` changes only on a readback. Cycles without one leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for loading, readback and mode capture |
| rstN | input | 1 | Synchronous active-low reset; the mode is sampled while it is low |
| wen1N | input | 1 | Active-low write enable |
| wen2Ld | input | 1 | Second write enable, or active-low load select in load mode |
| ren1N | input | 1 | Active-low read enable 1 |
| ren2N | input | 1 | Active-low read enable 2 |
| dataIn | input | 8 | Byte written into the selected slot |
| dataOut | output | 8 | Byte read back from a slot; holds between reads |
| emptyOffset | output | OFS_W | Assembled almost-empty offset |
| fullOffset | output | OFS_W | Assembled almost-full offset |
| loadMode | output | 1 | 1 when the pin was low during reset (load mode) |
| collision | output | 1 | One-cycle pulse after a simultaneous write and read request |

## Verification
The bench goes after the sequence pointers. It splits one five-byte load over two sessions, so the wrap and the resume both land on known slots. A design that restarted each session at slot 0, or that wrapped at the wrong count, would leave a byte in the wrong half of an offset. It reads past the fourth slot and issues a colliding request between reads. A shared pointer, or a read pointer that advanced on a collision, would return the wrong byte on the next readback. It writes all-ones into a high slot to catch unmasked bits. It then repeats load and read attempts after a reset that selects the second-enable mode, where any change to the offsets or `dataOut` exposes a mode latch that ignored the reset-time level.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

  localparam int SLOT_COUNT = 4;
  localparam int SLOT_W     = $clog2(SLOT_COUNT);

  // slot order is behaviour: the pointers walk these in sequence
  typedef enum logic [SLOT_W-1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  // strobes from the control to the register datapath
  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSel;
    logic              rdEn;
    logic [SLOT_W-1:0] rdSel;
  } ofs_strobe_t;

endpackage

// File: rtl/ofs_seq_ctrl.sv
module ofs_seq_ctrl
  import ofs_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wen1N,
  input  logic        wen2Ld,
  input  logic        ren1N,
  input  logic        ren2N,
  output ofs_strobe_t strb,
  output logic        loadMode,
  output logic        collision
);

  logic [SLOT_W-1:0] wrPtr;
  logic [SLOT_W-1:0] rdPtr;
  logic              wrReq;
  logic              rdReq;
  logic              loadSel;

  // the load select only counts in load mode
  assign loadSel = loadMode && !wen2Ld;
  assign wrReq   = loadSel && !wen1N;
  assign rdReq   = loadSel && !ren1N && !ren2N;

  always_comb begin
    strb       = '0;
    strb.wrEn  = wrReq;
    strb.wrSel = wrPtr;
    strb.rdEn  = rdReq && !wrReq;   // a write wins a same-cycle collision
    strb.rdSel = rdPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadMode  <= !wen2Ld;
      wrPtr     <= '0;
      rdPtr     <= '0;
      collision <= 1'b0;
    end else begin
      if (wrReq) begin
        wrPtr <= wrPtr + 1'b1;
      end
      if (rdReq && !wrReq) begin
        rdPtr <= rdPtr + 1'b1;
      end
      collision <= wrReq && rdReq;
    end
  end

  // R1: mode is frozen once reset is released
  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(loadMode));

  // R4: each write moves the write pointer one slot, wrapping
  a_r4_wr_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> (wrPtr == $past(wrPtr) + 1'b1));

  // R5: without a write the write pointer keeps its slot
  a_r5_wr_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> $stable(wrPtr));

  // R8: a collision leaves the read pointer where it was
  a_r8_collision_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && rdReq) |=> ($stable(rdPtr) && collision));

  // R9: outside load mode no strobe reaches the datapath
  a_r9_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    !loadMode |-> (!strb.wrEn && !strb.rdEn));

endmodule

// File: rtl/ofs_seq_regfile.sv
module ofs_seq_regfile
  import ofs_seq_pkg::*;
#(
  parameter int OFS_W       = 14,
  parameter int DEFAULT_OFS = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ofs_strobe_t      strb,
  input  logic [7:0]       dataIn,
  output logic [7:0]       dataOut,
  output logic [OFS_W-1:0] emptyOffset,
  output logic [OFS_W-1:0] fullOffset
);

  localparam int HI_W   = OFS_W - 8;
  localparam int PAD_W  = 8 - HI_W;
  localparam int N_OFS  = SLOT_COUNT / 2;
  localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(DEFAULT_OFS);

  logic [N_OFS*OFS_W-1:0] ofsBus;
  logic [7:0]             rdMux;

  // one low byte and one high part per offset; offset gi owns slots 2gi, 2gi+1
  for (genvar gi = 0; gi < N_OFS; gi++) begin : g_ofs
    localparam logic [SLOT_W-1:0] LO_SLOT = SLOT_W'(2 * gi);
    localparam logic [SLOT_W-1:0] HI_SLOT = SLOT_W'(2 * gi + 1);
    logic [7:0]      loByte;
    logic [HI_W-1:0] hiPart;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loByte <= DEF_VAL[7:0];
        hiPart <= DEF_VAL[OFS_W-1:8];
      end else if (strb.wrEn) begin
        if (strb.wrSel == LO_SLOT) loByte <= dataIn;
        if (strb.wrSel == HI_SLOT) hiPart <= dataIn[HI_W-1:0];
      end
    end

    assign ofsBus[gi*OFS_W +: OFS_W] = {hiPart, loByte};
  end

  assign emptyOffset = ofsBus[OFS_W-1:0];
  assign fullOffset  = ofsBus[2*OFS_W-1:OFS_W];

  always_comb begin
    case (slot_e'(strb.rdSel))
      SLOT_EMPTY_LO: rdMux = emptyOffset[7:0];
      SLOT_EMPTY_HI: rdMux = {{PAD_W{1'b0}}, emptyOffset[OFS_W-1:8]};
      SLOT_FULL_LO:  rdMux = fullOffset[7:0];
      default:       rdMux = {{PAD_W{1'b0}}, fullOffset[OFS_W-1:8]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (strb.rdEn) begin
      dataOut <= rdMux;
    end
  end

  // R7: a high slot reads back with its unused bits clear
  a_r7_hi_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel[0]) |=> (dataOut[7:HI_W] == '0));

  // R10: the byte output only moves on a readback
  a_r10_dout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(dataOut));

  // R3: offsets only move on a load write
  a_r3_ofs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> ($stable(emptyOffset) && $stable(fullOffset)));

endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_seq_pkg::*;
#(
  parameter int OFS_W       = 14,
  parameter int DEFAULT_OFS = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wen1N,
  input  logic             wen2Ld,
  input  logic             ren1N,
  input  logic             ren2N,
  input  logic [7:0]       dataIn,
  output logic [7:0]       dataOut,
  output logic [OFS_W-1:0] emptyOffset,
  output logic [OFS_W-1:0] fullOffset,
  output logic             loadMode,
  output logic             collision
);

  ofs_strobe_t strb;

  ofs_seq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wen1N     (wen1N),
    .wen2Ld    (wen2Ld),
    .ren1N     (ren1N),
    .ren2N     (ren2N),
    .strb      (strb),
    .loadMode  (loadMode),
    .collision (collision)
  );

  ofs_seq_regfile #(
    .OFS_W       (OFS_W),
    .DEFAULT_OFS (DEFAULT_OFS)
  ) i_regfile (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dataIn      (dataIn),
    .dataOut     (dataOut),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset)
  );

  // R2: the cycle after a reset shows the defaults
  a_r2_reset_defaults: assert property (@(posedge clk)
    (rstN && !$past(rstN)) |-> (emptyOffset == OFS_W'(DEFAULT_OFS) &&
                                fullOffset == OFS_W'(DEFAULT_OFS) &&
                                dataOut == 8'd0 && !collision));

endmodule

// File: tb/test_ofs_load_seq.sv
module test_ofs_load_seq;

  localparam int OFS_W = 14;
  localparam int HI_W  = OFS_W - 8;

  logic             clk = 1'b0;
  logic             rstN, wen1N, wen2Ld, ren1N, ren2N;
  logic [7:0]       dataIn;
  logic [7:0]       dataOut;
  logic [OFS_W-1:0] emptyOffset, fullOffset;
  logic             loadMode, collision;

  always #5 clk = ~clk;

  ofs_load_seq #(.OFS_W(OFS_W), .DEFAULT_OFS(7)) i_ofs_load_seq (
    .clk(clk), .rstN(rstN), .wen1N(wen1N), .wen2Ld(wen2Ld),
    .ren1N(ren1N), .ren2N(ren2N), .dataIn(dataIn), .dataOut(dataOut),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .loadMode(loadMode), .collision(collision)
  );

  // behavioural reference
  int  mLo[2];
  int  mHi[2];
  int  mWp, mRp, mDout;
  bit  mMode, mColl;
  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 0;

  task automatic modelEdge(input bit r, w1, w2, r1, r2, input int d);
    bit wr, rd;
    if (!r) begin
      mMode = !w2; mLo[0] = 7; mLo[1] = 7; mHi[0] = 0; mHi[1] = 0;
      mWp = 0; mRp = 0; mDout = 0; mColl = 0;
    end else begin
      wr = mMode && !w2 && !w1;
      rd = mMode && !w2 && !r1 && !r2;
      if (rd && !wr) begin
        mDout = (mRp % 2 == 0) ? mLo[mRp/2] : mHi[mRp/2];
        mRp = (mRp + 1) % 4;
      end
      if (wr) begin
        if (mWp % 2 == 0) mLo[mWp/2] = d;
        else              mHi[mWp/2] = d & ((1 << HI_W) - 1);
        mWp = (mWp + 1) % 4;
      end
      mColl = wr && rd;
    end
  endtask

  task automatic step(input bit r, w1, w2, r1, r2, input int d, input string tag);
    int expE, expF;
    rstN = r; wen1N = w1; wen2Ld = w2; ren1N = r1; ren2N = r2; dataIn = d[7:0];
    @(posedge clk);
    modelEdge(r, w1, w2, r1, r2, d);
    @(negedge clk);
    expE = mHi[0] * 256 + mLo[0];
    expF = mHi[1] * 256 + mLo[1];
    vectors++;
    if (int'(dataOut) != mDout || int'(emptyOffset) != expE ||
        int'(fullOffset) != expF || loadMode != mMode || collision != mColl) begin
      miscompares++;
      $display("FAIL %s: dout=%0h eo=%0h fo=%0h mode=%0b coll=%0b expected dout=%0h eo=%0h fo=%0h mode=%0b coll=%0b",
               tag, dataOut, emptyOffset, fullOffset, loadMode, collision,
               mDout, expE, expF, mMode, mColl);
    end
  endtask

  initial begin
    rstN = 0; wen1N = 1; wen2Ld = 0; ren1N = 1; ren2N = 1; dataIn = 0;
    @(negedge clk);
    // R1 R2: reset with load pin low selects load mode, defaults appear
    step(0, 1, 0, 1, 1, 0, "R1");
    step(0, 1, 0, 1, 1, 0, "R2");
    step(1, 1, 1, 1, 1, 0, "R1");
    // R10: load select alone moves nothing
    step(1, 1, 0, 1, 1, 8'h99, "R10");
    // R3 R7: first session writes slot 0 and an all-ones high slot
    step(1, 0, 0, 1, 1, 8'h21, "R3");
    step(1, 0, 0, 1, 1, 8'hFF, "R7");
    // R5: release load select, plain write enable has no effect on slots
    step(1, 0, 1, 1, 1, 8'h77, "R5");
    // R5 R4: second session resumes at slot 2 and wraps to slot 0
    step(1, 0, 0, 1, 1, 8'h35, "R5");
    step(1, 0, 0, 1, 1, 8'h02, "R3");
    step(1, 0, 0, 1, 1, 8'h44, "R4");
    // R6 R7: read all four and wrap
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, 0, "R6");
    // R10: one read enable inactive
    step(1, 1, 0, 1, 0, 0, "R10");
    step(1, 1, 0, 0, 1, 0, "R10");
    // R8: collision, then the next read shows the un-advanced slot
    step(1, 0, 0, 0, 0, 8'h55, "R8");
    step(1, 1, 0, 1, 1, 0, "R8");
    step(1, 1, 0, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, 0, "R6");
    step(1, 1, 0, 0, 0, 0, "R7");
    // R2: reset again in load mode, pointers back at slot 0
    step(0, 1, 0, 1, 1, 0, "R2");
    step(1, 1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 1, 1, 8'h10, "R2");
    step(1, 1, 0, 0, 0, 0, "R6");
    // R1 R9: reset with pin high selects second-enable mode
    step(0, 1, 1, 1, 1, 0, "R1");
    step(1, 0, 0, 1, 1, 8'hAA, "R9");
    step(1, 0, 0, 0, 0, 8'hBB, "R9");
    step(1, 1, 0, 0, 0, 0, "R9");
    step(1, 0, 1, 0, 0, 8'hCC, "R9");
    step(1, 1, 0, 1, 1, 0, "R1");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule